// File: doc/BRIEF.md
# Split Motion Vector Resolver

The block fills in the motion vectors of a 16x16 luma macroblock coded in split mode. The macroblock is a 4x4 grid of 4x4-pixel sub-blocks, and each sub-block has its own vector. The caller supplies a 2-bit reference tag for every sub-block. It also supplies a fresh vector for each sub-block tagged New. In addition it supplies the four vectors on the right column of the macroblock to the left and the four on the bottom row of the macroblock above, each group with an availability flag.

After a start pulse the block works through the sub-blocks one per clock in raster order: row 0 to row 3, and left to right within a row. A Left or Above tag therefore always refers to a vector that is already known. When the referenced neighbour falls outside the macroblock, the vector comes from the matching edge entry of the neighbouring macroblock. That entry is zero if the neighbour is flagged unavailable.

The sixteen results appear on one flat output bus. A single-cycle done pulse marks the end of the run. All inputs must stay stable while the block is busy.

Top module: `split_mv_resolver`

## Requirements
- R1: While reset is asserted and after it is released, `mv_out` is all zero and `busy` and `done` are low.
- R2: A `start` sampled high while idle raises `busy` on the next clock. One sub-block is written per clock, and `done` is high for exactly one cycle, 17 clocks after the start edge, with `busy` low at that point.
- R3: Sub-block i (i = 4*row + col) takes its tag from `tags[2i+1:2i]`. Its vector is stored at `mv_out[32i+31:32i]`, with the row component in the upper 16 bits and the column component in the lower 16 bits. A tag value of 2 (New) stores `new_mv[32i+31:32i]` unchanged.
- R4: A tag value of 0 (Left) in columns 1 to 3 copies the already resolved vector of sub-block i-1.
- R5: A tag value of 1 (Above) in rows 1 to 3 copies the already resolved vector of sub-block i-4.
- R6: A Left tag in column 0 of row r copies `left_edge[32r+31:32r]` when `left_ok` is high.
- R7: An Above tag in row 0 of column c copies `above_edge[32c+31:32c]` when `above_ok` is high.
- R8: A Left tag in column 0 with `left_ok` low, or an Above tag in row 0 with `above_ok` low, gives a zero vector.
- R9: A tag value of 3 (reserved) gives a zero vector.
- R10: Raster order lets copies chain. A row of Left tags spreads its source vector along the row, and a column of Above tags spreads its source vector down the column.
- R11: A `start` while busy neither restarts nor lengthens the run. While idle, `mv_out` holds its values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one macroblock |
| tags | input | 32 | Reference tag per sub-block, 2 bits each |
| new_mv | input | 512 | Fresh vector per sub-block, used when tagged New |
| left_edge | input | 128 | Right-column vectors of the left macroblock, one per row |
| left_ok | input | 1 | Left macroblock available |
| above_edge | input | 128 | Bottom-row vectors of the above macroblock, one per column |
| above_ok | input | 1 | Above macroblock available |
| mv_out | output | 512 | Sixteen resolved vectors |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle pulse after the last sub-block |

## Verification
The hardest case to reach is a long dependency chain, where a vector travels from a neighbour's edge entry through several copied sub-blocks, across both a row boundary and a column boundary. Only correct raster ordering and correct edge selection produce the right value at the end of such a chain. The stimulus builds this with tag patterns made entirely of Left tags, entirely of Above tags, and a mixed staircase. In each pattern every edge entry and fresh vector is distinct, so a value taken from the wrong source shows up in the output.

// File: rtl/split_mv_resolver.sv
module split_mv_resolver #(
  parameter int MV_W = 16,
  parameter int GRID = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [2*GRID*GRID-1:0]           tags,
  input  logic [2*MV_W*GRID*GRID-1:0]      new_mv,
  input  logic [2*MV_W*GRID-1:0]           left_edge,
  input  logic                             left_ok,
  input  logic [2*MV_W*GRID-1:0]           above_edge,
  input  logic                             above_ok,
  output logic [2*MV_W*GRID*GRID-1:0]      mv_out,
  output logic                             busy,
  output logic                             done
);
  localparam int VW  = 2 * MV_W;
  localparam int NSB = GRID * GRID;
  localparam int RW  = $clog2(GRID);
  localparam int IW  = 2 * RW;

  localparam logic [1:0] TAG_LEFT  = 2'd0;
  localparam logic [1:0] TAG_ABOVE = 2'd1;
  localparam logic [1:0] TAG_NEW   = 2'd2;

  logic [IW-1:0] idx;
  logic [RW-1:0] row, col;
  logic [1:0]    tag;
  logic [VW-1:0] left_v, above_v, res_v;

  assign row = idx[IW-1:RW];
  assign col = idx[RW-1:0];
  assign tag = tags[2*idx +: 2];

  always_comb begin
    if (col == '0)
      left_v = left_ok ? left_edge[int'(row)*VW +: VW] : '0;
    else
      left_v = mv_out[(int'(idx) - 1)*VW +: VW];
    if (row == '0)
      above_v = above_ok ? above_edge[int'(col)*VW +: VW] : '0;
    else
      above_v = mv_out[(int'(idx) - GRID)*VW +: VW];
    case (tag)
      TAG_LEFT:  res_v = left_v;
      TAG_ABOVE: res_v = above_v;
      TAG_NEW:   res_v = new_mv[int'(idx)*VW +: VW];
      default:   res_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      mv_out <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        mv_out[int'(idx)*VW +: VW] <= res_v;
        idx <= idx + 1'b1;
        if (int'(idx) == NSB - 1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end
  end
endmodule

// File: rtl/split_mv_resolver_chk.sv
module split_mv_resolver_chk #(
  parameter int MV_W = 16,
  parameter int GRID = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic [2*$clog2(GRID)-1:0]   idx,
  input logic [2*GRID*GRID-1:0]      tags,
  input logic [2*MV_W*GRID*GRID-1:0] new_mv,
  input logic [2*MV_W*GRID*GRID-1:0] mv_out
);
  localparam int VW  = 2 * MV_W;
  localparam int IW  = 2 * $clog2(GRID);
  localparam int NSB = GRID * GRID;

  logic [IW-1:0] prev_idx;
  logic [1:0]    cur_tag;
  logic [VW-1:0] cur_new, wr_v;

  always_ff @(posedge clk) prev_idx <= idx;

  assign cur_tag = tags[2*idx +: 2];
  assign cur_new = new_mv[int'(idx)*VW +: VW];
  assign wr_v    = mv_out[int'(prev_idx)*VW +: VW];

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(idx) != NSB - 1) |=> (busy && idx == IW'($past(idx) + 1'b1)));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(mv_out));
  a_r3_new_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_tag == 2'd2) |=> (wr_v == $past(cur_new)));
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_tag == 2'd3) |=> (wr_v == '0));
endmodule

bind split_mv_resolver split_mv_resolver_chk #(.MV_W(MV_W), .GRID(GRID)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .idx(idx), .tags(tags), .new_mv(new_mv), .mv_out(mv_out)
);

// File: tb/split_mv_resolver_test.sv
module split_mv_resolver_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  tags = '0;
  logic [511:0] new_mv = '0;
  logic [127:0] left_edge = '0, above_edge = '0;
  logic         left_ok = 1'b0, above_ok = 1'b0;
  logic [511:0] mv_out;
  logic         busy, done;

  int checks = 0, fails = 0;

  split_mv_resolver uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tags(tags), .new_mv(new_mv),
    .left_edge(left_edge), .left_ok(left_ok), .above_edge(above_edge),
    .above_ok(above_ok), .mv_out(mv_out), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] model();
    logic [511:0] m = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int i = 4*r + c;
        logic [31:0] v;
        case (tags[2*i +: 2])
          2'd0: v = (c == 0) ? (left_ok ? left_edge[32*r +: 32] : 32'd0) : m[32*(i-1) +: 32];
          2'd1: v = (r == 0) ? (above_ok ? above_edge[32*c +: 32] : 32'd0) : m[32*(i-4) +: 32];
          2'd2: v = new_mv[32*i +: 32];
          default: v = 32'd0;
        endcase
        m[32*i +: 32] = v;
      end
    return m;
  endfunction

  task automatic fill_sources(input int seed);
    for (int i = 0; i < 16; i++)
      new_mv[32*i +: 32] = {16'(seed + 16'h100 + i), 16'(-(seed + i + 1))};
    for (int k = 0; k < 4; k++) begin
      left_edge[32*k +: 32]  = {16'(16'h4000 + seed + k), 16'(16'hA000 + k)};
      above_edge[32*k +: 32] = {16'(16'hB000 + seed + k), 16'(16'h2000 + k)};
    end
  endtask

  task automatic run(input string req, input bit poke_busy);
    int n = 0;
    logic [511:0] exp = model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    check("R2 busy after start", {511'd0, busy}, 512'd1);
    while (!done && n < 40) begin
      if (poke_busy && n == 5) start = 1'b1;
      if (poke_busy && n == 6) start = 1'b0;
      @(negedge clk); n++;
    end
    check("R2 done cycle", 512'(n), 512'd17);
    check("R2 busy low at done", {511'd0, busy}, 512'd0);
    check(req, mv_out, exp);
    @(negedge clk);
    check("R2 done single cycle", {511'd0, done}, 512'd0);
  endtask

  task automatic t_reset();
    check("R1 mv_out reset", mv_out, '0);
    check("R1 busy/done reset", {510'd0, busy, done}, '0);
  endtask

  task automatic t_all_new();
    fill_sources(3); left_ok = 1; above_ok = 1;
    tags = {16{2'd2}};
    run("R3 all new", 0);
  endtask

  task automatic t_all_left(input bit ok);
    fill_sources(7); left_ok = ok; above_ok = 1;
    tags = '0;
    run(ok ? "R6 R10 left chains from edge" : "R8 left unavailable", 0);
  endtask

  task automatic t_all_above(input bit ok);
    fill_sources(11); left_ok = 1; above_ok = ok;
    tags = {16{2'd1}};
    run(ok ? "R7 R10 above chains from edge" : "R8 above unavailable", 0);
  endtask

  task automatic t_interior();
    fill_sources(21); left_ok = 1; above_ok = 1;
    tags = {16{2'd2}};
    tags[2*5 +: 2] = 2'd0; tags[2*6 +: 2] = 2'd0;
    tags[2*9 +: 2] = 2'd1; tags[2*14 +: 2] = 2'd1;
    run("R4 R5 interior copies", 0);
  endtask

  task automatic t_staircase();
    fill_sources(33); left_ok = 1; above_ok = 1;
    for (int i = 0; i < 16; i++) tags[2*i +: 2] = ((i % 4) >= (i / 4)) ? 2'd0 : 2'd1;
    tags[2*0 +: 2] = 2'd2;
    run("R10 mixed staircase", 0);
  endtask

  task automatic t_reserved();
    fill_sources(45); left_ok = 1; above_ok = 1;
    for (int i = 0; i < 16; i++) tags[2*i +: 2] = (i % 3 == 0) ? 2'd3 : 2'(i % 3 - 1);
    run("R9 reserved tag zero", 0);
  endtask

  task automatic t_busy_start();
    fill_sources(51); left_ok = 1; above_ok = 0;
    tags = 32'h9C6E_1B27;
    run("R11 start during busy ignored", 1);
  endtask

  task automatic t_idle_hold();
    logic [511:0] held = mv_out;
    fill_sources(77); tags = ~tags; left_ok = ~left_ok;
    repeat (5) @(negedge clk);
    check("R11 idle hold", mv_out, held);
    check("R11 idle stays idle", {510'd0, busy, done}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_new();
    t_all_left(1);
    t_all_left(0);
    t_all_above(1);
    t_all_above(0);
    t_interior();
    t_staircase();
    t_reserved();
    t_busy_start();
    t_idle_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule